// File: doc/BRIEF.md
# MII PHY Discovery and Link Resolver

This block sits on the management side of an Ethernet port. After a start pulse it looks for an attached PHY by scanning management addresses. It reads the PHY's identifier register and sorts the PHY into a family. It then waits for the link to come up and reads the status register that belongs to that family. From that register it reports the resolved line speed and the duplex mode. The block contains its own serial management frame engine, which drives the clock, the data output and the output enable, and samples the data input.

The management clock is the system clock divided by a parameter. The engine changes its output only while that clock is low and samples the input on its rising edge. All results are registered and become valid on a single-cycle `done` pulse. The `busy` output stays high from the accepted start until that pulse.

Top module: `phy_probe_top`

## Requirements
- R1: After reset, busy, done, found, link_up, speed_unknown, mdc and mdio_oe are 0, and speed, phy_class and phy_addr are 0.
- R2: Every management frame is a read made of 32 preamble ones, start bits 0 then 1, opcode bits 1 then 0, a 5-bit PHY address and a 5-bit register number, each sent most significant bit first. mdio_oe is low for the two turnaround bits and for the 16 data bits, which are sampled most significant bit first.
- R3: mdc toggles every CLK_DIV system clock cycles.
- R4: The scan reads register 1 at addresses 1, 2, 3 and so on up to 31, in that order. It accepts the first address whose value is neither 0xFFFF nor 0x0000, then reads register 2 at that address.
- R5: When no address is accepted, done rises with found=0, phy_addr=0, phy_class=0, link_up=0 and speed=0.
- R6: The identifier 0x0016 gives phy_class 1, 0x0022 gives 2, 0x0141 gives 3, 0x0302 gives 4 and 0x0013 gives 5. Any other value gives 7. Classes 1, 2 and 4 read status register 18; classes 3 and 5 read register 17.
- R7: For class 1, status bit 7 gives speed 2 (100M), otherwise speed 1 (10M). Bit 6 gives full_duplex.
- R8: For classes 2 and 4, status bit 10 gives speed 2, otherwise speed 1. Bit 11 gives full_duplex.
- R9: For class 3, bit 13 gives full_duplex. Bits 15:14 give speed 3 (1000M) when 10, speed 2 when 01, and speed 1 otherwise.
- R10: For class 5, bit 9 gives full_duplex. Bits 15:14 give speed 3 when 11, speed 2 when 10, and speed 1 otherwise.
- R11: The link is polled through bit 2 of register 1 for at most LINK_POLLS reads. Polling stops at the first read with the bit set, which sets link_up. If no read has the bit set, link_up=0, speed=0, full_duplex=0, and no status register is read.
- R12: For class 7 with the link up, no status register is read, speed=0 and speed_unknown=1.
- R13: busy stays high from the accepted start until the cycle in which done pulses. A start pulse during busy does not change the frames issued or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts discovery |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data in |
| busy | output | 1 | Discovery in progress |
| done | output | 1 | One-cycle pulse: results valid |
| found | output | 1 | A PHY answered |
| phy_addr | output | 5 | Address of the accepted PHY |
| phy_class | output | 3 | Family code (R6) |
| link_up | output | 1 | Link bit seen during polling |
| speed | output | 2 | 0 none, 1 10M, 2 100M, 3 1000M |
| full_duplex | output | 1 | Resolved duplex |
| speed_unknown | output | 1 | Link up but family has no decode |

## Verification
The bench attaches a behavioural PHY that decodes every frame bit by bit and answers from a programmable register set. This catches any slip of one bit position in the header or the data, and any late release of the data line during turnaround. The scan is tested with an address that returns zeros before the live PHY, with the PHY at the last address, and with no PHY at all. A design that skipped one rejection value or stopped one address early would report the wrong address or a wrong found flag. Each family's status layout is tested with several bit patterns. These include the 11 pattern of the 15:14 field, which means different speeds in the two families that use it, so a swapped decode reports the wrong speed. Link polling is tested with the link never up and with the link up on a later poll, and the frame count shows whether the poll limit or the skipped status read is wrong.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int MDIO_DW    = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = PRE_BITS + 4 + PHY_AW + REG_AW;
  localparam int FRAME_BITS = HDR_BITS + 2 + MDIO_DW;
  localparam int LINK_BIT   = 2;

  localparam logic [REG_AW-1:0] REG_BASIC_STAT = 5'd1;
  localparam logic [REG_AW-1:0] REG_IDENT      = 5'd2;
  localparam logic [REG_AW-1:0] REG_VSTAT_17   = 5'd17;
  localparam logic [REG_AW-1:0] REG_VSTAT_18   = 5'd18;

  typedef enum logic [2:0] {
    CLS_NONE    = 3'd0,
    CLS_ID0016  = 3'd1,
    CLS_ID0022  = 3'd2,
    CLS_ID0141  = 3'd3,
    CLS_ID0302  = 3'd4,
    CLS_ID0013  = 3'd5,
    CLS_GENERIC = 3'd7
  } phy_class_e;

  typedef enum logic [1:0] {
    SPD_NONE = 2'd0,
    SPD_10   = 2'd1,
    SPD_100  = 2'd2,
    SPD_1000 = 2'd3
  } speed_e;
endpackage

// File: rtl/phy_mdc_gen.sv
module phy_mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);
  localparam logic [CW-1:0] TERM = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          term;

  assign term      = (cnt == TERM);
  assign rise_tick = term & ~mdc;
  assign fall_tick = term & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phy_mdio_frame.sv
module phy_mdio_frame
  import phy_probe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               go,
  input  logic [PHY_AW-1:0]  phy,
  input  logic [REG_AW-1:0]  regn,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               fin,
  output logic               idle,
  output logic [MDIO_DW-1:0] rdata
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] TA_BIT   = BW'(HDR_BITS);
  localparam logic [BW-1:0] DATA_BIT = BW'(HDR_BITS + 2);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_RUN} fst_e;

  fst_e                st;
  logic [HDR_BITS-1:0] shreg;
  logic [BW-1:0]       bitn;

  assign idle = (st == F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      shreg   <= '0;
      bitn    <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      fin     <= 1'b0;
      rdata   <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        F_IDLE: begin
          if (go) begin
            shreg <= {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy, regn};
            bitn  <= '0;
            st    <= F_WAIT;
          end
        end
        default: begin
          if (fall_tick) begin
            st <= F_RUN;
            if (bitn < TA_BIT) begin
              mdio_oe <= 1'b1;
              mdio_o  <= shreg[HDR_BITS-1];
              shreg   <= {shreg[HDR_BITS-2:0], 1'b0};
            end else begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
            end
          end
          if (rise_tick && st == F_RUN) begin
            if (bitn >= DATA_BIT) rdata <= {rdata[MDIO_DW-2:0], mdio_i};
            if (bitn == LAST_BIT) begin
              st  <= F_IDLE;
              fin <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/phy_decode.sv
module phy_decode
  import phy_probe_pkg::*;
(
  input  logic [MDIO_DW-1:0] ident,
  input  phy_class_e         cls,
  input  logic [MDIO_DW-1:0] vstat,
  output phy_class_e         cls_of_id,
  output logic [REG_AW-1:0]  stat_reg,
  output speed_e             spd,
  output logic               dup
);
  always_comb begin
    case (ident)
      16'h0016: cls_of_id = CLS_ID0016;
      16'h0022: cls_of_id = CLS_ID0022;
      16'h0141: cls_of_id = CLS_ID0141;
      16'h0302: cls_of_id = CLS_ID0302;
      16'h0013: cls_of_id = CLS_ID0013;
      default:  cls_of_id = CLS_GENERIC;
    endcase
  end

  always_comb begin
    stat_reg = REG_VSTAT_18;
    spd      = SPD_NONE;
    dup      = 1'b0;
    case (cls)
      CLS_ID0016: begin
        spd = vstat[7] ? SPD_100 : SPD_10;
        dup = vstat[6];
      end
      CLS_ID0022, CLS_ID0302: begin
        spd = vstat[10] ? SPD_100 : SPD_10;
        dup = vstat[11];
      end
      CLS_ID0141: begin
        stat_reg = REG_VSTAT_17;
        dup      = vstat[13];
        case (vstat[15:14])
          2'b10:   spd = SPD_1000;
          2'b01:   spd = SPD_100;
          default: spd = SPD_10;
        endcase
      end
      CLS_ID0013: begin
        stat_reg = REG_VSTAT_17;
        dup      = vstat[9];
        case (vstat[15:14])
          2'b11:   spd = SPD_1000;
          2'b10:   spd = SPD_100;
          default: spd = SPD_10;
        endcase
      end
      default: begin
        spd = SPD_NONE;
        dup = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/phy_probe_top.sv
module phy_probe_top
  import phy_probe_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int LINK_POLLS = 4096,
  parameter int FIRST_ADDR = 1,
  parameter int LAST_ADDR  = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        found,
  output logic [4:0]  phy_addr,
  output logic [2:0]  phy_class,
  output logic        link_up,
  output logic [1:0]  speed,
  output logic        full_duplex,
  output logic        speed_unknown
);
  localparam int PCW = $clog2(LINK_POLLS + 1);
  localparam logic [PCW-1:0]    POLL_LAST = PCW'(LINK_POLLS - 1);
  localparam logic [PHY_AW-1:0] ADDR_LO   = PHY_AW'(FIRST_ADDR);
  localparam logic [PHY_AW-1:0] ADDR_HI   = PHY_AW'(LAST_ADDR);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_ID, S_LINK, S_STAT} st_e;

  st_e                state;
  logic               wait_rsp;
  logic [PHY_AW-1:0]  cur_addr;
  logic [REG_AW-1:0]  cur_reg;
  logic [PCW-1:0]     polls;
  phy_class_e         cls_q;
  logic               rise_tick, fall_tick;
  logic               eng_go, eng_fin, eng_idle;
  logic [MDIO_DW-1:0] eng_rdata;
  phy_class_e         cls_of_id;
  logic [REG_AW-1:0]  stat_reg;
  speed_e             dec_spd;
  logic               dec_dup;
  logic               rsp_live;

  assign phy_class = cls_q;
  assign eng_go    = (state != S_IDLE) && !wait_rsp && eng_idle;
  assign rsp_live  = (eng_rdata != 16'hFFFF) && (eng_rdata != 16'h0000);

  always_comb begin
    case (state)
      S_ID:    cur_reg = REG_IDENT;
      S_STAT:  cur_reg = stat_reg;
      default: cur_reg = REG_BASIC_STAT;
    endcase
  end

  phy_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  phy_mdio_frame u_frame (
    .clk(clk), .rst(rst), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .go(eng_go), .phy(cur_addr), .regn(cur_reg), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .fin(eng_fin), .idle(eng_idle),
    .rdata(eng_rdata)
  );

  phy_decode u_dec (
    .ident(eng_rdata), .cls(cls_q), .vstat(eng_rdata),
    .cls_of_id(cls_of_id), .stat_reg(stat_reg), .spd(dec_spd), .dup(dec_dup)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      wait_rsp      <= 1'b0;
      cur_addr      <= '0;
      polls         <= '0;
      cls_q         <= CLS_NONE;
      busy          <= 1'b0;
      done          <= 1'b0;
      found         <= 1'b0;
      phy_addr      <= '0;
      link_up       <= 1'b0;
      speed         <= SPD_NONE;
      full_duplex   <= 1'b0;
      speed_unknown <= 1'b0;
    end else begin
      done <= 1'b0;
      if (eng_go) wait_rsp <= 1'b1;
      case (state)
        S_IDLE: begin
          if (start) begin
            busy          <= 1'b1;
            found         <= 1'b0;
            phy_addr      <= '0;
            cls_q         <= CLS_NONE;
            link_up       <= 1'b0;
            speed         <= SPD_NONE;
            full_duplex   <= 1'b0;
            speed_unknown <= 1'b0;
            cur_addr      <= ADDR_LO;
            state         <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (eng_fin) begin
            wait_rsp <= 1'b0;
            if (rsp_live) begin
              found    <= 1'b1;
              phy_addr <= cur_addr;
              state    <= S_ID;
            end else if (cur_addr == ADDR_HI) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              cur_addr <= cur_addr + 1'b1;
            end
          end
        end
        S_ID: begin
          if (eng_fin) begin
            wait_rsp <= 1'b0;
            cls_q    <= cls_of_id;
            polls    <= '0;
            state    <= S_LINK;
          end
        end
        S_LINK: begin
          if (eng_fin) begin
            wait_rsp <= 1'b0;
            if (eng_rdata[LINK_BIT]) begin
              link_up <= 1'b1;
              if (cls_q == CLS_GENERIC) begin
                speed_unknown <= 1'b1;
                busy          <= 1'b0;
                done          <= 1'b1;
                state         <= S_IDLE;
              end else begin
                state <= S_STAT;
              end
            end else if (polls == POLL_LAST) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        S_STAT: begin
          if (eng_fin) begin
            wait_rsp    <= 1'b0;
            speed       <= dec_spd;
            full_duplex <= dec_dup;
            busy        <= 1'b0;
            done        <= 1'b1;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_probe_chk.sv
module phy_probe_chk (
  input logic       clk,
  input logic       rst,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       done,
  input logic       found,
  input logic [2:0] phy_class,
  input logic       link_up,
  input logic [1:0] speed,
  input logic       speed_unknown
);
  a_r13_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r13_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r2_data_moves_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  a_r2_no_drive_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  a_r11_speed_needs_link: assert property (@(posedge clk) disable iff (rst)
    (speed != 2'd0) |-> (link_up && found));

  a_r12_unknown_only_generic: assert property (@(posedge clk) disable iff (rst)
    speed_unknown |-> (phy_class == 3'd7 && link_up && speed == 2'd0));

  a_r5_class_needs_found: assert property (@(posedge clk) disable iff (rst)
    (phy_class != 3'd0) |-> found);
endmodule

bind phy_probe_top phy_probe_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .done(done), .found(found), .phy_class(phy_class),
  .link_up(link_up), .speed(speed), .speed_unknown(speed_unknown)
);

// File: tb/tb_phy_probe_top.sv
`timescale 1ns/1ps
module tb_phy_probe_top;
  localparam int CLK_DIV_T = 2;
  localparam int POLLS_T   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, busy, done, found, link_up, full_duplex, speed_unknown;
  logic [4:0] phy_addr;
  logic [2:0] phy_class;
  logic [1:0] speed;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  phy_probe_top #(.CLK_DIV(CLK_DIV_T), .LINK_POLLS(POLLS_T)) dut (
    .clk(clk), .rst(rst), .start(start), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .busy(busy), .done(done),
    .found(found), .phy_addr(phy_addr), .phy_class(phy_class),
    .link_up(link_up), .speed(speed), .full_duplex(full_duplex),
    .speed_unknown(speed_unknown)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural PHY ----------------
  int          m_addr = 0;
  int          m_zero = -1;
  logic [15:0] m_id = 16'h0;
  logic [15:0] m_stat = 16'h0;
  int          m_link_after = 0;
  int          m_link_reads = 0;

  int          f_addr [64];
  int          f_reg  [64];
  int          nframes = 0;
  int          hdr_err = 0;
  int          ta_err = 0;
  int          ones = 0;
  int          pos = -1;
  logic [12:0] hbits;
  logic [15:0] resp;

  function automatic logic [15:0] phy_reg(input int a, input int r);
    if (a == m_zero) return 16'h0000;
    if (a != m_addr || m_addr == 0) return 16'hFFFF;
    if (r == 1) begin
      m_link_reads++;
      return (m_link_reads > m_link_after) ? 16'h7809 | 16'h0004 : 16'h7809;
    end
    if (r == 2) return m_id;
    if (r == 17 || r == 18) return m_stat;
    return 16'hFFFF;
  endfunction

  always @(posedge mdc) begin
    if (pos < 0) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin pos = 1; hbits = '0; end
      else ones = 0;
    end else begin
      pos++;
      if (pos <= 14) hbits = {hbits[11:0], mdio_o};
      if (pos == 14) begin
        if (hbits[12:10] != 3'b110) hdr_err++;
        if (nframes < 64) begin
          f_addr[nframes] = int'(hbits[9:5]);
          f_reg[nframes]  = int'(hbits[4:0]);
        end
        nframes++;
        resp = phy_reg(int'(hbits[9:5]), int'(hbits[4:0]));
      end
      if (pos >= 15 && mdio_oe) ta_err++;
      if (pos == 32) begin pos = -1; ones = 0; end
    end
  end

  always @(negedge mdc) begin
    if (pos >= 16 && pos <= 31) mdio_i = resp[31 - pos];
    else mdio_i = 1'b1;
  end

  // ---------------- MDC period monitor (R3) ----------------
  int ccount = 0;
  int per_err = 0;
  int per_seen = 0;
  logic pmdc = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      ccount++;
      if (mdc != pmdc) begin
        if (per_seen > 0 && ccount != CLK_DIV_T) per_err++;
        per_seen++;
        ccount = 0;
      end
      pmdc = mdc;
    end
  end

  // ---------------- expected-value model ----------------
  function automatic void expect_dec(input logic [15:0] id, input logic [15:0] st,
                                     output int cls, output int spd, output int dup,
                                     output int sreg);
    cls = 7; spd = 0; dup = 0; sreg = 0;
    case (id)
      16'h0016: begin cls = 1; sreg = 18; spd = st[7] ? 2 : 1; dup = st[6]; end
      16'h0022: begin cls = 2; sreg = 18; spd = st[10] ? 2 : 1; dup = st[11]; end
      16'h0302: begin cls = 4; sreg = 18; spd = st[10] ? 2 : 1; dup = st[11]; end
      16'h0141: begin
        cls = 3; sreg = 17; dup = st[13];
        spd = (st[15:14] == 2'b10) ? 3 : (st[15:14] == 2'b01) ? 2 : 1;
      end
      16'h0013: begin
        cls = 5; sreg = 17; dup = st[9];
        spd = (st[15:14] == 2'b11) ? 3 : (st[15:14] == 2'b10) ? 2 : 1;
      end
      default: ;
    endcase
  endfunction

  int busy_low_seen;

  task automatic run_case(input int addr, input int zero, input logic [15:0] id,
                          input logic [15:0] st, input int link_after,
                          input bit poke_busy);
    int cls, spd, dup, sreg, scans, lreads, exp_frames, wd;
    bit lnk;
    string dtag;
    m_addr = addr; m_zero = zero; m_id = id; m_stat = st;
    m_link_after = link_after; m_link_reads = 0;
    nframes = 0; hdr_err = 0; ta_err = 0;
    expect_dec(id, st, cls, spd, dup, sreg);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    busy_low_seen = 0;
    wd = 0;
    while (!done && wd < 30000) begin
      if (poke_busy && wd == 600) start = 1'b1;
      if (poke_busy && wd == 601) start = 1'b0;
      if (!busy) busy_low_seen++;
      @(negedge clk); wd++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R13: done never rose actual=0 expected=1");
      return;
    end
    chk("R13 busy held until done", busy_low_seen, 0);
    chk("R13 busy low at done", int'(busy), 0);
    chk("R2 header start/opcode bits", hdr_err, 0);
    chk("R2 mdio released in turnaround/data", ta_err, 0);
    if (addr == 0) begin
      chk("R5 found", int'(found), 0);
      chk("R5 phy_addr", int'(phy_addr), 0);
      chk("R5 phy_class", int'(phy_class), 0);
      chk("R5 link_up", int'(link_up), 0);
      chk("R5 speed", int'(speed), 0);
      chk("R4 frames in full scan", nframes, 31);
      for (int i = 0; i < 31; i++) chk("R4 scan order", f_addr[i], i + 1);
      return;
    end
    scans = addr;
    lnk = (link_after < POLLS_T + 1);
    lreads = lnk ? ((link_after + 1 > 2 ? link_after + 1 : 2) - 1) : POLLS_T;
    exp_frames = scans + 1 + lreads + ((lnk && cls != 7) ? 1 : 0);
    chk("R4 found", int'(found), 1);
    chk("R4 phy_addr", int'(phy_addr), addr);
    for (int i = 0; i < scans; i++) begin
      chk("R4 scan address order", f_addr[i], i + 1);
      chk("R4 scan reads register 1", f_reg[i], 1);
    end
    chk("R4 id read register", f_reg[scans], 2);
    chk("R4 id read address", f_addr[scans], addr);
    chk("R6 phy_class", int'(phy_class), cls);
    chk("R11 frame count", nframes, exp_frames);
    chk("R11 link_up", int'(link_up), int'(lnk));
    if (!lnk) begin
      chk("R11 speed without link", int'(speed), 0);
      chk("R11 duplex without link", int'(full_duplex), 0);
      return;
    end
    if (cls == 7) begin
      chk("R12 speed generic", int'(speed), 0);
      chk("R12 speed_unknown", int'(speed_unknown), 1);
      return;
    end
    chk("R6 status register number", f_reg[nframes - 1], sreg);
    dtag = (cls == 1) ? "R7" : (cls == 3) ? "R9" : (cls == 5) ? "R10" : "R8";
    chk({dtag, " speed"}, int'(speed), spd);
    chk({dtag, " duplex"}, int'(full_duplex), dup);
    chk("R12 speed_unknown clear", int'(speed_unknown), 0);
    if (poke_busy) begin
      int hi = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (busy) hi++; end
      chk("R13 start during busy ignored", hi, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 found", int'(found), 0);
    chk("R1 mdio_oe", int'(mdio_oe), 0);
    chk("R1 mdc", int'(mdc), 0);
    chk("R1 speed", int'(speed), 0);
    chk("R1 phy_class", int'(phy_class), 0);
    chk("R1 phy_addr", int'(phy_addr), 0);
    chk("R1 link_up", int'(link_up), 0);
    chk("R1 speed_unknown", int'(speed_unknown), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    run_case(1, -1, 16'h0016, 16'h00C0, 0, 1'b0);
    run_case(5,  3, 16'h0016, 16'h0000, 0, 1'b0);
    run_case(2, -1, 16'h0022, 16'h0400, 0, 1'b0);
    run_case(7, -1, 16'h0302, 16'h0800, 0, 1'b0);
    run_case(1, -1, 16'h0141, 16'hA000, 0, 1'b0);
    run_case(1, -1, 16'h0141, 16'h4000, 0, 1'b0);
    run_case(1, -1, 16'h0141, 16'hC000, 0, 1'b0);
    run_case(1, -1, 16'h0013, 16'hC200, 0, 1'b0);
    run_case(1, -1, 16'h0013, 16'h8000, 0, 1'b0);
    run_case(1, -1, 16'h0013, 16'h4200, 0, 1'b0);
    run_case(3, -1, 16'h1234, 16'h0000, 0, 1'b0);
    run_case(1, -1, 16'h0016, 16'h00C0, 100, 1'b0);
    run_case(1, -1, 16'h0022, 16'h0C00, 2, 1'b0);
    run_case(31, -1, 16'h0302, 16'h0C00, 0, 1'b0);
    run_case(0, -1, 16'h0000, 16'h0000, 0, 1'b0);
    run_case(4, -1, 16'h0141, 16'h6000, 0, 1'b1);

    chk("R3 mdc half period", per_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule